// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers event pulses from a set of peripheral sources and presents at most one interrupt request to a processor. Each source carries a four-bit level set through a small write port. Level 0 switches a source off. Levels 1 to 15 are active, and 15 is the most urgent. Any number of sources may share a level. The controller reports the index and level of the winning pending source beside a single request line.

The controller remembers which levels are in service. When the processor takes a request (enter strobe), the level of that request goes onto an internal stack and becomes the current threshold. From then on, only a pending source whose level is strictly above the threshold can raise the request line again. This lets an urgent event interrupt a handler that is already running. When the processor finishes a handler (exit strobe), the stack pops and the threshold drops back to the level that was interrupted. Events that were held back are then delivered in order of urgency.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the active level is 0, no source is pending and every source level is 0.
- R2: A source at level 0 never causes a request. A pulse that arrives while its level is 0 is not latched, so raising its level later does not by itself cause a request.
- R3: Among the pending sources, the one with the highest level wins, and `irq_id_o` and `irq_level_o` report it. A pulse sampled at clock edge k shows on the request line after edge k+1.
- R4: When several pending sources share the highest level, the source with the lowest index wins.
- R5: An enter strobe while the request line is high does three things. It clears the pending bit of the reported source. It makes the reported level the active level. It drives the request line low for the following cycle.
- R6: While a level is active, pending sources at that level or below do not raise the request line.
- R7: A pending source whose level is strictly above the active level raises the request line, which preempts the running handler.
- R8: An exit strobe restores the level that was active before the most recent enter. Events that were held back are then delivered, highest level first.
- R9: An enter strobe while the request line is low has no effect. An exit strobe while no level is active has no effect.
- R10: A write on the configuration port sets the level of source `cfg_idx_i` to `cfg_level_i`, and later arbitration uses the new level.
- R11: If a source pulses in the same cycle in which it is acknowledged, its pending bit stays set.
- R12: Nesting reaches 15 levels deep, one for each active level. The exit strobes then unwind them in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | N_SRC | One-cycle event pulse per source |
| cfg_we_i | input | 1 | Level write enable |
| cfg_idx_i | input | IDW | Source index to write |
| cfg_level_i | input | 4 | Level value to write |
| enter_i | input | 1 | Processor takes the presented request |
| exit_i | input | 1 | Processor finished the current handler |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_id_o | output | IDW | Index of the winning source |
| irq_level_o | output | 4 | Level of the winning source |
| active_level_o | output | 4 | Level currently in service, 0 when idle |

## Verification
The bench targets the points where a nested controller usually goes wrong, and states what a faulty design would show at each:
- Equal-level events during service: a `>=` comparison in place of `>` would let them re-raise the request.
- Ties: an arbiter that keeps the last match would report the higher index.
- The acknowledge cycle: if the request is not masked there, the same source would be taken twice.
- Simultaneous pulse and acknowledge: if clear wins over set, an event would be lost.
- The full 15-deep nest and its unwinding: a stack that loses an entry would return to the wrong threshold.
- Stray strobes: an enter or exit with nothing to act on would corrupt the active level.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int LVL_W   = 4;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_prio_regs.sv
`timescale 1ns/1ps
module pic_prio_regs
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDW-1:0]         idx,
  input  lvl_t                   wlvl,
  output logic [N_SRC*LVL_W-1:0] lvl_flat
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    lvl_t lvl_q;
    always_ff @(posedge clk) begin
      if (rst)                             lvl_q <= '0;
      else if (we && idx == IDW'(i))       lvl_q <= wlvl;
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/pic_pending.sv
`timescale 1ns/1ps
module pic_pending
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       pulse,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  input  logic                   clr_en,
  input  logic [IDW-1:0]         clr_idx,
  output logic [N_SRC-1:0]       pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic set_c, clr_c, pend_q;
    assign set_c = pulse[i] && (lvl_flat[i*LVL_W +: LVL_W] != '0);
    assign clr_c = clr_en && (clr_idx == IDW'(i));
    always_ff @(posedge clk) begin
      if (rst)        pend_q <= 1'b0;
      else if (set_c) pend_q <= 1'b1;
      else if (clr_c) pend_q <= 1'b0;
    end
    assign pend[i] = pend_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output lvl_t                   win_lvl,
  output logic [IDW-1:0]         win_idx
);
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && lvl_flat[i*LVL_W +: LVL_W] > win_lvl) begin
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
        win_idx = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_level_stack.sv
`timescale 1ns/1ps
module pic_level_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = NUM_LVL,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  lvl_t           push_lvl,
  input  logic           pop,
  output lvl_t           top_lvl,
  output logic [SPW-1:0] depth
);
  lvl_t           mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic           do_push, do_pop;

  assign do_push = push && (sp_q < SPW'(DEPTH));
  assign do_pop  = pop && !push && (sp_q != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_q] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)          sp_q <= '0;
    else if (do_push) sp_q <= sp_q + 1'b1;
    else if (do_pop)  sp_q <= sp_q - 1'b1;
  end

  assign top_lvl = (sp_q == '0) ? '0 : mem[sp_q - 1'b1];
  assign depth   = sp_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_pulse_i,
  input  logic             cfg_we_i,
  input  logic [IDW-1:0]   cfg_idx_i,
  input  logic [3:0]       cfg_level_i,
  input  logic             enter_i,
  input  logic             exit_i,
  output logic             irq_o,
  output logic [IDW-1:0]   irq_id_o,
  output logic [3:0]       irq_level_o,
  output logic [3:0]       active_level_o
);
  localparam int SPW = $clog2(NUM_LVL + 1);

  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic [N_SRC-1:0]       pend;
  lvl_t                   win_lvl, thr;
  logic [IDW-1:0]         win_idx;
  logic [SPW-1:0]         stk_depth;
  logic                   irq_q, take;
  logic [IDW-1:0]         id_q;
  lvl_t                   lvl_q;

  assign take = enter_i && irq_q;

  pic_prio_regs #(.N_SRC(N_SRC), .IDW(IDW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we_i), .idx(cfg_idx_i),
    .wlvl(cfg_level_i), .lvl_flat(lvl_flat)
  );

  pic_pending #(.N_SRC(N_SRC), .IDW(IDW)) u_pend (
    .clk(clk), .rst(rst), .pulse(src_pulse_i), .lvl_flat(lvl_flat),
    .clr_en(take), .clr_idx(id_q), .pend(pend)
  );

  pic_arbiter #(.N_SRC(N_SRC), .IDW(IDW)) u_arb (
    .pend(pend), .lvl_flat(lvl_flat), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  pic_level_stack #(.DEPTH(NUM_LVL), .SPW(SPW)) u_stk (
    .clk(clk), .rst(rst), .push(take), .push_lvl(lvl_q),
    .pop(exit_i), .top_lvl(thr), .depth(stk_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= !take && (win_lvl > thr);
      id_q  <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assign irq_o          = irq_q;
  assign irq_id_o       = id_q;
  assign irq_level_o    = lvl_q;
  assign active_level_o = thr;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int DEPTH = 15,
  parameter int SPW   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           enter_i,
  input logic           exit_i,
  input logic           irq_o,
  input logic [3:0]     irq_level_o,
  input logic [3:0]     active_level_o,
  input logic [SPW-1:0] stk_depth
);
  p_never_level0_r2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_level_o != 4'd0);

  p_above_active_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_level_o > active_level_o);

  p_enter_push_r5: assert property (@(posedge clk) disable iff (rst)
    (enter_i && irq_o) |=> (active_level_o == $past(irq_level_o)) && !irq_o);

  p_exit_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_i && !(enter_i && irq_o) && stk_depth != '0)
      |=> active_level_o < $past(active_level_o));

  p_exit_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (exit_i && !(enter_i && irq_o) && stk_depth == '0) |=> active_level_o == 4'd0);

  p_enter_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (enter_i && !irq_o && !exit_i) |=> $stable(active_level_o));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    stk_depth <= SPW'(DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DEPTH(pic_pkg::NUM_LVL), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .enter_i(enter_i), .exit_i(exit_i), .irq_o(irq_o),
  .irq_level_o(irq_level_o), .active_level_o(active_level_o), .stk_depth(stk_depth)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0;
  logic         we = 1'b0;
  logic [W-1:0] widx = '0;
  logic [3:0]   wlvl = '0;
  logic         enter = 1'b0, leave = 1'b0;
  logic         irq;
  logic [W-1:0] id;
  logic [3:0]   lvl, act;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u0 (
    .clk(clk), .rst(rst), .src_pulse_i(src), .cfg_we_i(we), .cfg_idx_i(widx),
    .cfg_level_i(wlvl), .enter_i(enter), .exit_i(leave), .irq_o(irq),
    .irq_id_o(id), .irq_level_o(lvl), .active_level_o(act)
  );

  // entry = {pulse mask[14:7], expected id[6:4], expected level[3:0]}; level 0 = no request
  localparam logic [14:0] VEC [8] = '{
    {8'h01, 3'd0, 4'd3}, {8'h06, 3'd1, 4'd7}, {8'h08, 3'd0, 4'd0}, {8'h21, 3'd0, 4'd3},
    {8'hC0, 3'd6, 4'd12}, {8'hFF, 3'd4, 4'd15}, {8'h28, 3'd5, 4'd1}, {8'h84, 3'd7, 4'd12}
  };

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string req, int actv, int expv);
    checks++;
    if (actv != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic cfg(int s, int l);
    we = 1'b1; widx = W'(s); wlvl = 4'(l); tick; we = 1'b0;
  endtask
  task automatic pulse(logic [N-1:0] m); src = m; tick; src = '0; tick; endtask
  task automatic do_enter; enter = 1'b1; tick; enter = 1'b0; endtask
  task automatic do_exit; leave = 1'b1; tick; leave = 1'b0; tick; endtask
  task automatic drain;
    for (int k = 0; k < 20 && irq; k++) begin do_enter; do_exit; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick; tick; rst = 1'b0; tick;
    chk("R1 irq", irq, 0); chk("R1 active", act, 0);
    pulse(8'hFF); chk("R1 levels zero, no request", irq, 0);

    cfg(0, 3); cfg(1, 7); cfg(2, 7); cfg(3, 0);
    cfg(4, 15); cfg(5, 1); cfg(6, 12); cfg(7, 12);
    for (int v = 0; v < 8; v++) begin
      pulse(VEC[v][14:7]);
      chk("R3/R4 irq", irq, (VEC[v][3:0] != 0));
      if (VEC[v][3:0] != 0) begin
        chk("R3/R4 id", id, VEC[v][6:4]);
        chk("R3 level", lvl, VEC[v][3:0]);
      end
      drain;
      chk("R8 drained", irq, 0);
    end

    // R2: level 0 pulse not latched
    pulse(8'h08); cfg(3, 9); tick; tick;
    chk("R2 stale pulse", irq, 0);
    // R10: new level used
    pulse(8'h08); chk("R10 id", id, 3); chk("R10 level", lvl, 9);
    drain;

    // R6/R7/R8 nesting
    pulse(8'h02); chk("R3 id", id, 1);
    do_enter; chk("R5 irq low", irq, 0); chk("R5 active", act, 7);
    tick; chk("R5 pending cleared", irq, 0);
    pulse(8'h04); chk("R6 equal held", irq, 0);
    pulse(8'h20); chk("R6 lower held", irq, 0);
    pulse(8'h10); chk("R7 preempt", irq, 1); chk("R7 id", id, 4);
    do_enter; chk("R7 active", act, 15);
    do_exit; chk("R8 back to 7", act, 7); chk("R8 still held", irq, 0);
    do_exit; chk("R8 idle", act, 0); chk("R8 deferred id", id, 2); chk("R8 irq", irq, 1);
    do_enter; do_exit; chk("R8 next id", id, 5); chk("R8 next level", lvl, 1);
    do_enter; do_exit; chk("R8 all done", irq, 0);

    // R9: stray strobes
    do_enter; tick; chk("R9 enter idle", act, 0);
    do_exit; chk("R9 exit empty", act, 0);
    pulse(8'h01); chk("R9 still works", id, 0);
    do_enter; chk("R9 after stray", act, 3); do_exit;

    // R11: pulse with acknowledge
    pulse(8'h10); chk("R11 id", id, 4);
    enter = 1'b1; src = 8'h10; tick; enter = 1'b0; src = '0;
    chk("R11 active", act, 15); tick; chk("R11 held", irq, 0);
    do_exit; chk("R11 kept", irq, 1); chk("R11 id again", id, 4);
    drain;

    // R12: full nest
    for (int l = 1; l <= 15; l++) begin
      cfg(0, l); pulse(8'h01);
      chk("R12 irq", irq, 1); chk("R12 level", lvl, l);
      do_enter; chk("R12 active", act, l);
    end
    for (int l = 15; l >= 1; l--) begin
      chk("R12 unwind", act, l); do_exit;
    end
    chk("R12 empty", act, 0); chk("R12 no irq", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule